// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Alternate-Function Ownership

This block is an eight-pin general-purpose I/O port whose pins are also wanted by two on-chip peripherals. Every pin has a PWM channel of the same index. Every pin is also part of a routed SPI group. Pins 0 to 3 serve SPI instance 0 and pins 4 to 7 serve SPI instance 1. Within a group the pin order is MISO, MOSI, SS, SCK, starting at the group's lowest pin. A fixed priority decides the owner of each pin. An enabled PWM channel wins. Failing that, an enabled SPI instance wins. Otherwise plain GPIO drives the pin from its data and direction registers.

Software reaches the port over a small register bus. It has a data register at address 0 and a direction register at address 1, and both can be written and read at any time. When the data register is read, each bit is chosen separately by its direction bit. An output bit returns the value software latched. An input bit returns the pad level after a two-flop synchronizer. A value written while a peripheral owns the pin is stored, and it reaches the pad as soon as GPIO gets the pin back.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the data register and the direction register both read as 0x00, and with no peripheral enabled `pad_oe` is 0x00.
- R2: A write with `reg_sel`=1, `reg_we`=1 stores `reg_wdata` in the register chosen by `reg_addr`, where 0 selects data and 1 selects direction. Reading address 1 returns the direction register. A read requires `reg_sel`=1, and `reg_rdata` is 0 when `reg_sel`=0.
- R3: On a read of address 0, any bit whose direction bit is 1 returns the latched data bit.
- R4: On a read of address 0, any bit whose direction bit is 0 returns `pad_in` through a two-flop synchronizer. A pad change shows after the second rising clock edge following it and not after the first.
- R5: A pin with neither its PWM channel nor its SPI instance enabled drives `pad_out` from the data bit and `pad_oe` from the direction bit.
- R6: When `pwm_en[n]` is 1, pin n drives `pad_out[n]`=`pwm_out[n]` with `pad_oe[n]`=1, whatever the SPI enables and the registers hold.
- R7: When `pwm_en[n]` is 0 and the SPI instance for pin n is enabled (`spi_en[0]` for pins 0 to 3, `spi_en[1]` for pins 4 to 7), pin n drives `pad_out[n]`=`spi_out[n]` and `pad_oe[n]`=`spi_oe[n]`. The other group is not affected.
- R8: A data write while a peripheral owns the pin is stored and can be read back. It does not reach `pad_out` until ownership returns to GPIO, and then it does.
- R9: `spi_in` always equals `pad_in`, so the SPI blocks see the raw pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 1 | 0 selects data, 1 selects direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data; 0 when not selected |
| pwm_en | input | 8 | PWM channel enable for each pin |
| pwm_out | input | 8 | PWM waveform for each pin |
| spi_en | input | 2 | Enable for SPI instance 0 (pins 0-3) and instance 1 (pins 4-7) |
| spi_out | input | 8 | SPI output value for each pin |
| spi_oe | input | 8 | SPI output enable for each pin |
| spi_in | output | 8 | Pad levels passed to the SPI blocks |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The hardest situation to reach from the ports is a data write that lands while a peripheral holds the pin. The bench enables every PWM channel, writes a data pattern that differs from the PWM waveform, and confirms that the pads still follow PWM while the register already reads back the new pattern. It then releases the pins and checks that the pattern appears on the pads. The synchronizer delay is checked by changing `pad_in` just after an edge and reading before and after the second following edge. Pin priority is checked with enable patterns in which PWM and SPI overlap on some pins and not on others.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;

    // Ownership of one pin, in rising priority
    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_SPI  = 2'd1,
        OWN_PWM  = 2'd2
    } pin_owner_e;

    // Pins per SPI group: MISO, MOSI, SS, SCK from the group's lowest pin
    localparam int unsigned SPI_GROUP_PINS = 4;

    localparam logic REG_ADDR_DATA = 1'b0;
    localparam logic REG_ADDR_DIR  = 1'b1;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];

    // Count edges since reset so the delay check never looks before reset
    logic [1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
    end

    // R4: output lags the pad by two edges (default depth)
    a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && since_rst_q == 2'd2) |-> (q_out == $past(d_in, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_altfn_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] reg_rdata
);

    logic wr_data, wr_dir;
    assign wr_data = reg_sel && reg_we && (reg_addr == REG_ADDR_DATA);
    assign wr_dir  = reg_sel && reg_we && (reg_addr == REG_ADDR_DIR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= reg_wdata;
            if (wr_dir)  dir_q  <= reg_wdata;
        end
    end

    logic [WIDTH-1:0] data_view;
    always_comb begin
        for (int b = 0; b < WIDTH; b++) begin
            data_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
        end
    end

    always_comb begin
        if (!reg_sel)                     reg_rdata = '0;
        else if (reg_addr == REG_ADDR_DIR) reg_rdata = dir_q;
        else                              reg_rdata = data_view;
    end

    // R2: a data write lands on the next edge
    a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (data_q == $past(reg_wdata)));
    // R2: a direction write lands on the next edge
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(reg_wdata)));
    // R8: the latch holds when not written, whoever owns the pin
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(data_q));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_altfn_pkg::*;
(
    input  logic       pwm_en,
    input  logic       pwm_o,
    input  logic       spi_en,
    input  logic       spi_o,
    input  logic       spi_oe,
    input  logic       gpio_d,
    input  logic       gpio_dir,
    output logic       pad_o,
    output logic       pad_oe,
    output pin_owner_e owner
);

    always_comb begin
        if (pwm_en)      owner = OWN_PWM;
        else if (spi_en) owner = OWN_SPI;
        else             owner = OWN_GPIO;
    end

    always_comb begin
        unique case (owner)
            OWN_PWM: begin
                pad_o  = pwm_o;
                pad_oe = 1'b1;
            end
            OWN_SPI: begin
                pad_o  = spi_o;
                pad_oe = spi_oe;
            end
            default: begin
                pad_o  = gpio_d;
                pad_oe = gpio_dir;
            end
        endcase
    end

endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
    import gpio_altfn_pkg::*;
#(
    parameter int unsigned NPINS       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_sel,
    input  logic                                reg_we,
    input  logic                                reg_addr,
    input  logic [NPINS-1:0]                    reg_wdata,
    output logic [NPINS-1:0]                    reg_rdata,
    input  logic [NPINS-1:0]                    pwm_en,
    input  logic [NPINS-1:0]                    pwm_out,
    input  logic [NPINS/SPI_GROUP_PINS-1:0]     spi_en,
    input  logic [NPINS-1:0]                    spi_out,
    input  logic [NPINS-1:0]                    spi_oe,
    output logic [NPINS-1:0]                    spi_in,
    input  logic [NPINS-1:0]                    pad_in,
    output logic [NPINS-1:0]                    pad_out,
    output logic [NPINS-1:0]                    pad_oe
);

    localparam int unsigned NGROUPS = NPINS / SPI_GROUP_PINS;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    pin_owner_e       owner [NPINS];

    gpio_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .q_out (pin_sync)
    );

    gpio_regs #(
        .WIDTH (NPINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .reg_rdata (reg_rdata)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            gpio_pin_mux u_mux (
                .pwm_en   (pwm_en[p]),
                .pwm_o    (pwm_out[p]),
                .spi_en   (spi_en[p / SPI_GROUP_PINS]),
                .spi_o    (spi_out[p]),
                .spi_oe   (spi_oe[p]),
                .gpio_d   (data_q[p]),
                .gpio_dir (dir_q[p]),
                .pad_o    (pad_out[p]),
                .pad_oe   (pad_oe[p]),
                .owner    (owner[p])
            );

            // R6: an enabled PWM channel drives its pin
            a_r6_pwm_drives: assert property (@(posedge clk) disable iff (!rst_n)
                pwm_en[p] |-> (pad_oe[p] && pad_out[p] == pwm_out[p]));
            // R7: SPI drives the pin when PWM is off
            a_r7_spi_drives: assert property (@(posedge clk) disable iff (!rst_n)
                (!pwm_en[p] && spi_en[p / SPI_GROUP_PINS]) |->
                    (pad_oe[p] == spi_oe[p] && pad_out[p] == spi_out[p]));
            // R5: GPIO drives from the registers when both peripherals are off
            a_r5_gpio_drives: assert property (@(posedge clk) disable iff (!rst_n)
                (!pwm_en[p] && !spi_en[p / SPI_GROUP_PINS]) |->
                    (pad_oe[p] == dir_q[p] && pad_out[p] == data_q[p]));
        end
    endgenerate

    assign spi_in = pad_in;

    // R1: nothing drives a pin in the first cycle out of reset without a peripheral
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && pwm_en == '0 && spi_en == '0) |-> (pad_oe == '0));

    initial begin
        assert (NGROUPS * SPI_GROUP_PINS == NPINS)
            else $error("NPINS must be a multiple of the SPI group size");
    end

endmodule

// File: tb/sim_gpio_altfn_port.sv
module sim_gpio_altfn_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pwm_en = '0, pwm_out = '0;
    logic [1:0] spi_en = '0;
    logic [7:0] spi_out = '0, spi_oe = '0;
    logic [7:0] spi_in;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_altfn_port u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_en(pwm_en), .pwm_out(pwm_out),
        .spi_en(spi_en), .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        v = reg_rdata;
        reg_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        bus_read(1'b0, v); chk("R1 data after reset", v, 8'h00);
        bus_read(1'b1, v); chk("R1 dir after reset", v, 8'h00);
        chk("R1 pad_oe after reset", pad_oe, 8'h00);
        #1; chk("R2 rdata idle without sel", reg_rdata, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        bus_write(1'b1, 8'hFF);
        bus_write(1'b0, 8'hA5);
        bus_read(1'b1, v); chk("R2 dir readback", v, 8'hFF);
        bus_read(1'b0, v); chk("R3 output bits read latch", v, 8'hA5);
        chk("R5 gpio pad_out", pad_out, 8'hA5);
        chk("R5 gpio pad_oe", pad_oe, 8'hFF);
    endtask

    task automatic t_mixed_dir();
        logic [7:0] v;
        bus_write(1'b1, 8'h0F);
        bus_write(1'b0, 8'h3C);
        pad_in = 8'hC3;
        repeat (3) @(negedge clk);
        bus_read(1'b0, v); chk("R3 R4 mixed readback", v, 8'hCC);
        chk("R5 mixed pad_oe", pad_oe, 8'h0F);
        chk("R5 mixed pad_out", pad_out, 8'h3C);
    endtask

    task automatic t_sync_delay();
        logic [7:0] v;
        bus_write(1'b1, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        bus_read(1'b0, v); chk("R4 not visible after one edge", v, 8'h00);
        @(negedge clk);
        bus_read(1'b0, v); chk("R4 visible after two edges", v, 8'h5A);
    endtask

    task automatic t_pwm_priority();
        bus_write(1'b1, 8'h00);
        pwm_en = 8'h81; pwm_out = 8'h80;
        spi_en = 2'b11; spi_out = 8'hFF; spi_oe = 8'hFF;
        #1;
        chk("R6 pwm over spi pad_out", pad_out, 8'hFE);
        chk("R6 pwm over spi pad_oe", pad_oe, 8'hFF);
        spi_oe = 8'h00;
        #1;
        chk("R6 pwm forces oe", pad_oe, 8'h81);
        pwm_en = 8'h00; spi_en = 2'b00; spi_out = 8'h00;
    endtask

    task automatic t_spi_groups();
        bus_write(1'b1, 8'hF0);
        bus_write(1'b0, 8'hF0);
        spi_en = 2'b01; spi_out = 8'h3A; spi_oe = 8'h05;
        #1;
        chk("R7 group0 pad_out", pad_out, 8'hFA);
        chk("R7 group0 pad_oe", pad_oe, 8'hF5);
        spi_en = 2'b10;
        #1;
        chk("R7 group1 pad_out", pad_out, 8'h30);
        chk("R7 group1 pad_oe", pad_oe, 8'h00);
        spi_en = 2'b00; spi_out = 8'h00; spi_oe = 8'h00;
    endtask

    task automatic t_write_while_owned();
        logic [7:0] v;
        pwm_en = 8'hFF; pwm_out = 8'h00;
        bus_write(1'b1, 8'hFF);
        bus_write(1'b0, 8'h99);
        chk("R8 pad unchanged while owned", pad_out, 8'h00);
        bus_read(1'b0, v); chk("R8 stored while owned", v, 8'h99);
        @(negedge clk);
        pwm_en = 8'h00;
        #1;
        chk("R8 applied on release", pad_out, 8'h99);
    endtask

    task automatic t_spi_in();
        pad_in = 8'h6C;
        #1; chk("R9 spi_in follows pad", spi_in, 8'h6C);
        pad_in = 8'h93;
        #1; chk("R9 spi_in follows pad again", spi_in, 8'h93);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_mixed_dir();
        t_sync_delay();
        t_pwm_priority();
        t_spi_groups();
        t_write_while_owned();
        t_spi_in();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule